// File: doc/BRIEF.md
# Regular Expression Matcher Circuit

This block recognises one fixed regular expression over single-bit input signals. It is built from small construct circuits, and each of them has the same small interface: a start input, a match output and a prefix output. The constructs are the empty string, a signal test, concatenation, repetition (zero or more times) and alternation. The expression is fixed when the design is elaborated: `(ε + C)* + (A.B)`, where A, B and C are separate input pins.

A recognition attempt begins in any cycle where `start_i` is high. The signal inputs are sampled from that cycle onward. `match_o` is high in a cycle when the values seen since some start form a word of the language. `prefix_o` is high while at least one attempt could still grow into a word. Attempts can overlap, so each cycle reports the union of all attempts that are alive.

Two separate start outputs guard the repetition construct. The empty-string part of its body is fed only from the outside start. Only registered matches from the body feed back into the body's start. This keeps the loop free of combinational cycles.

Top module: `rx_matcher`

## Requirements
- R1: While `rst` is high, all internal state clears. With `start_i` low, `match_o` and `prefix_o` then read low.
- R2: In every cycle where `start_i` is high, `match_o` and `prefix_o` are both high in that same cycle. This is the empty word, or zero repetitions.
- R3: Take a start in cycle t, with `sig_c_i` high in each of cycles t .. t+k-1 (k ≥ 1). Then `match_o` is high in cycle t+k.
- R4: Take a start in cycle t with `sig_a_i` high, and `sig_b_i` high in cycle t+1. Then `match_o` is high in cycle t+2.
- R5: Take a start in cycle t with `sig_a_i` high and `sig_c_i` low, and no other live attempt. Then cycle t+1 shows `prefix_o` high and `match_o` low.
- R6: Take a cycle with `prefix_o` low, followed by a cycle with `start_i` low. In that next cycle both outputs are low, whatever `sig_a_i`, `sig_b_i` and `sig_c_i` hold.
- R7: When attempts overlap, the outputs in each cycle are the logical OR, over all starts, of what each start alone would produce.
- R8: `match_o` is never high while `prefix_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Begins a recognition attempt in this cycle |
| sig_a_i | input | 1 | Signal A: first symbol of the A.B branch |
| sig_b_i | input | 1 | Signal B: second symbol of the A.B branch |
| sig_c_i | input | 1 | Signal C: symbol of the repeated branch |
| match_o | output | 1 | Input seen since some start is a word of the language |
| prefix_o | output | 1 | Some attempt is still alive |

## Verification
The bench runs every three-cycle pattern of start and the three signals, then watches two idle cycles with the signals held high. Together these cover the following cases:
- A zero-repetition match in the start cycle itself. A loop that fed only registered matches to its output would miss it.
- A broken C run. A loop that kept circulating after a low C would keep matching.
- An A followed by a missing B. Here the prefix must drop.
- A B with no A before it. A sequence that began at its second element would match here.
- Back-to-back and overlapping starts, run in a long pseudo-random phase. A design that kept only one attempt at a time would lose matches here.

// File: rtl/rx_pkg.sv
package rx_pkg;

  // Common output pair of every construct circuit.
  typedef struct packed {
    logic match;
    logic prefix;
  } rx_tap_t;

  localparam rx_tap_t RX_IDLE = '{match: 1'b0, prefix: 1'b0};

  // Alternation: union of both branches.
  function automatic rx_tap_t rx_union(input rx_tap_t x, input rx_tap_t y);
    rx_tap_t r;
    r.match  = x.match | y.match;
    r.prefix = x.prefix | y.prefix;
    return r;
  endfunction

  // Concatenation: the word completes only in the tail; either part may be alive.
  function automatic rx_tap_t rx_chain(input rx_tap_t head, input rx_tap_t tail);
    rx_tap_t r;
    r.match  = tail.match;
    r.prefix = head.prefix | tail.prefix;
    return r;
  endfunction

  // Repetition output: the empty word is accepted at every start.
  function automatic rx_tap_t rx_nullable(input logic start, input rx_tap_t body);
    rx_tap_t r;
    r.match  = start | body.match;
    r.prefix = start | body.prefix;
    return r;
  endfunction

  // Re-entry of a repetition body: outside start or a completed pass.
  function automatic logic rx_reenter(input logic start, input rx_tap_t body);
    return start | body.match;
  endfunction

endpackage

// File: rtl/rx_empty.sv
module rx_empty
  import rx_pkg::*;
(
  input  logic    start_i,
  output rx_tap_t out_o
);
  // The empty word is complete in the cycle it starts, and alive only then.
  always_comb begin
    out_o.match  = start_i;
    out_o.prefix = start_i;
  end
endmodule

// File: rtl/rx_sig.sv
module rx_sig
  import rx_pkg::*;
#(
  parameter logic RESET_VAL = 1'b0
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    start_i,
  input  logic    sig_i,
  output rx_tap_t out_o
);
  logic hit_q;

  // One symbol is consumed per cycle; the result shows one cycle later.
  always_ff @(posedge clk) begin
    if (rst) hit_q <= RESET_VAL;
    else     hit_q <= start_i & sig_i;
  end

  always_comb begin
    out_o.match  = hit_q;
    out_o.prefix = hit_q;
  end
endmodule

// File: rtl/rx_seq.sv
module rx_seq
  import rx_pkg::*;
(
  input  logic    start_i,
  input  rx_tap_t head_i,
  input  rx_tap_t tail_i,
  output logic    head_start_o,
  output logic    tail_start_o,
  output rx_tap_t out_o
);
  // The tail starts exactly where the head completes.
  assign head_start_o = start_i;
  assign tail_start_o = head_i.match;
  assign out_o        = rx_chain(head_i, tail_i);
endmodule

// File: rtl/rx_alt.sv
module rx_alt
  import rx_pkg::*;
(
  input  logic    left_go_i,
  input  logic    right_go_i,
  input  rx_tap_t left_i,
  input  rx_tap_t right_i,
  output logic    left_start_o,
  output logic    right_start_o,
  output rx_tap_t out_o
);
  // Each branch takes its start from its own input. An ordinary choice
  // ties both to one start. Inside a repetition, a branch that accepts
  // the empty word takes the guarded (outside-only) start.
  assign left_start_o  = left_go_i;
  assign right_start_o = right_go_i;
  assign out_o         = rx_union(left_i, right_i);
endmodule

// File: rtl/rx_star.sv
module rx_star
  import rx_pkg::*;
(
  input  logic    start_i,
  input  rx_tap_t body_i,
  output logic    lead_start_o,
  output logic    body_start_o,
  output rx_tap_t out_o
);
  // lead_start_o carries only the outside start. Body parts that accept
  // the empty word combinationally must use it. body_start_o also
  // carries completed passes, and only parts with a registered entry
  // may use it, so the feedback path always crosses a flop.
  assign lead_start_o = start_i;
  assign body_start_o = rx_reenter(start_i, body_i);
  assign out_o        = rx_nullable(start_i, body_i);
endmodule

// File: rtl/rx_matcher.sv
module rx_matcher
  import rx_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic sig_a_i,
  input  logic sig_b_i,
  input  logic sig_c_i,
  output logic match_o,
  output logic prefix_o
);
  // Expression: (eps + C)* + (A . B)

  // Outer alternation
  logic    star_start, seq_start;
  rx_tap_t star_t, seq_t, top_t;

  // Repetition branch
  logic    loop_lead_w, loop_go_w;
  logic    eps_start, c_start;
  rx_tap_t body_t, eps_t, c_t;

  // Concatenation branch
  logic    a_start, b_start;
  rx_tap_t a_t, b_t;

  // Named internal events for the checker
  logic    loop_hit_w;
  logic    ab_mid_w;

  rx_alt u_top_alt (
    .left_go_i    (start_i),
    .right_go_i   (start_i),
    .left_i       (star_t),
    .right_i      (seq_t),
    .left_start_o (star_start),
    .right_start_o(seq_start),
    .out_o        (top_t)
  );

  rx_star u_star (
    .start_i     (star_start),
    .body_i      (body_t),
    .lead_start_o(loop_lead_w),
    .body_start_o(loop_go_w),
    .out_o       (star_t)
  );

  rx_alt u_body_alt (
    .left_go_i    (loop_lead_w),
    .right_go_i   (loop_go_w),
    .left_i       (eps_t),
    .right_i      (c_t),
    .left_start_o (eps_start),
    .right_start_o(c_start),
    .out_o        (body_t)
  );

  rx_empty u_eps (
    .start_i(eps_start),
    .out_o  (eps_t)
  );

  rx_sig u_sig_c (
    .clk    (clk),
    .rst    (rst),
    .start_i(c_start),
    .sig_i  (sig_c_i),
    .out_o  (c_t)
  );

  rx_seq u_seq (
    .start_i     (seq_start),
    .head_i      (a_t),
    .tail_i      (b_t),
    .head_start_o(a_start),
    .tail_start_o(b_start),
    .out_o       (seq_t)
  );

  rx_sig u_sig_a (
    .clk    (clk),
    .rst    (rst),
    .start_i(a_start),
    .sig_i  (sig_a_i),
    .out_o  (a_t)
  );

  rx_sig u_sig_b (
    .clk    (clk),
    .rst    (rst),
    .start_i(b_start),
    .sig_i  (sig_b_i),
    .out_o  (b_t)
  );

  assign loop_hit_w = c_t.match;
  assign ab_mid_w   = a_t.match;

  assign match_o  = top_t.match;
  assign prefix_o = top_t.prefix;

endmodule

// File: rtl/rx_matcher_checker.sv
module rx_matcher_checker (
  input logic clk,
  input logic rst,
  input logic start_i,
  input logic sig_a_i,
  input logic sig_b_i,
  input logic sig_c_i,
  input logic match_o,
  input logic prefix_o,
  input logic loop_go_w,
  input logic loop_hit_w,
  input logic ab_mid_w
);

  assert_empty_on_start_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |-> (match_o && prefix_o));

  assert_c_from_start_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(start_i) && $past(sig_c_i)) |-> match_o);

  assert_c_reentry_R3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(loop_go_w) && $past(sig_c_i)) |-> (loop_hit_w && match_o));

  assert_ab_word_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst, 1) && !$past(rst, 2) && $past(start_i, 2) && $past(sig_a_i, 2)
     && $past(sig_b_i, 1)) |-> match_o);

  assert_a_keeps_alive_R5: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(start_i) && $past(sig_a_i)) |-> (ab_mid_w && prefix_o));

  assert_quiet_stays_R6: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(prefix_o) && !start_i) |-> (!match_o && !prefix_o));

  assert_match_in_prefix_R8: assert property (@(posedge clk) disable iff (rst)
    match_o |-> prefix_o);

endmodule

bind rx_matcher rx_matcher_checker u_rx_checker (
  .clk       (clk),
  .rst       (rst),
  .start_i   (start_i),
  .sig_a_i   (sig_a_i),
  .sig_b_i   (sig_b_i),
  .sig_c_i   (sig_c_i),
  .match_o   (match_o),
  .prefix_o  (prefix_o),
  .loop_go_w (loop_go_w),
  .loop_hit_w(loop_hit_w),
  .ab_mid_w  (ab_mid_w)
);

// File: tb/rx_matcher_tb_top.sv
`timescale 1ns/1ps
module rx_matcher_tb_top;

  localparam int HMAX      = 4096;
  localparam int SWEEP_LEN = 3;
  localparam int RAND_LEN  = 1500;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, sig_a_i = 1'b0, sig_b_i = 1'b0, sig_c_i = 1'b0;
  logic match_o, prefix_o;

  always #4 clk = ~clk;  // 125 MHz

  rx_matcher dut_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .sig_a_i (sig_a_i),
    .sig_b_i (sig_b_i),
    .sig_c_i (sig_c_i),
    .match_o (match_o),
    .prefix_o(prefix_o)
  );

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;
  int  t_now    = 0;
  bit  hs [HMAX];
  bit  ha [HMAX];
  bit  hb [HMAX];
  bit  hc [HMAX];

  // Reference: union over all starts s <= t of the language (C)^k or exactly "A then B".
  function automatic bit ref_match(int t);
    if (hs[t]) return 1'b1;
    if (t >= 2 && hs[t-2] && ha[t-2] && hb[t-1]) return 1'b1;
    for (int s = t - 1; s >= 0; s--) begin
      if (!hc[s]) break;
      if (hs[s]) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic bit ref_prefix(int t);
    if (ref_match(t)) return 1'b1;
    if (t >= 1 && hs[t-1] && ha[t-1]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic check(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s at step %0d: actual=%b expected=%b", tag, what, t_now, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; start_i = 1'b0; sig_a_i = 1'b1; sig_b_i = 1'b1; sig_c_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R1", "match in reset", match_o, 1'b0);
    check("R1", "prefix in reset", prefix_o, 1'b0);
    rst = 1'b0;
    t_now = 0;
  endtask

  // Called at a falling edge: drive, settle, compare, advance to the next falling edge.
  task automatic step(logic st, logic a, logic b, logic c, string force_tag);
    bit em, ep, prev_alive;
    string tag;
    start_i = st; sig_a_i = a; sig_b_i = b; sig_c_i = c;
    hs[t_now] = st; ha[t_now] = a; hb[t_now] = b; hc[t_now] = c;
    #1;
    em = ref_match(t_now);
    ep = ref_prefix(t_now);
    prev_alive = (t_now > 0) ? ref_prefix(t_now - 1) : 1'b0;
    if (force_tag != "")                                           tag = force_tag;
    else if (st)                                                   tag = "R2";
    else if (em && t_now >= 2 && hs[t_now-2] && ha[t_now-2] && hb[t_now-1]) tag = "R4";
    else if (em)                                                   tag = "R3";
    else if (ep)                                                   tag = "R5";
    else if (!prev_alive)                                          tag = "R6";
    else                                                           tag = "R3";
    check(tag, "match", match_o, em);
    check(tag, "prefix", prefix_o, ep);
    check("R8", "match without prefix", match_o & ~prefix_o, 1'b0);
    t_now++;
    @(negedge clk);
  endtask

  initial begin
    logic [15:0] lfsr;
    @(negedge clk);
    do_reset();

    // Directed cases
    step(1, 0, 0, 1, "R2");  // start, C
    step(0, 0, 0, 1, "R3");  // C run continues
    step(0, 0, 0, 0, "R3");  // run breaks after this cycle
    step(0, 1, 1, 1, "R6");  // nothing alive: inputs ignored
    step(1, 1, 0, 0, "R2");  // start with A
    step(0, 0, 1, 1, "R5");  // A pending, B now
    step(0, 0, 0, 0, "R4");  // A.B completes
    step(1, 0, 1, 0, "R2");  // B without A
    step(0, 1, 1, 1, "R6");  // dead attempt
    do_reset();

    // Exhaustive sweep of every 3-cycle pattern of {start,a,b,c}
    for (int pat = 0; pat < (1 << (4 * SWEEP_LEN)); pat++) begin
      do_reset();
      for (int k = 0; k < SWEEP_LEN; k++) begin
        logic [3:0] v;
        v = 4'((pat >> (4 * k)) & 15);
        step(v[3], v[2], v[1], v[0], "");
      end
      step(0, 1, 1, 1, "");
      step(0, 1, 1, 1, "");
    end

    // Overlapping starts, pseudo-random
    do_reset();
    lfsr = 16'hACE1;
    for (int k = 0; k < RAND_LEN; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], lfsr[1], lfsr[2], lfsr[3] | lfsr[7], "R7");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fails++;
      $display("FAIL watchdog expired: actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

endmodule